// File: doc/BRIEF.md
# Data Operand Address Generator

This block sits in front of the load/store unit of a small 8-bit microcontroller core. For every memory-operand request it forms the effective address of the operand. The address can come from one of three 16-bit index pointers, a pointer plus a short unsigned offset, a 6-bit peripheral-register number, or a full 16-bit address word extended by an 8-bit segment register. When the addressing mode moves a pointer, the block also produces the updated pointer value and a write-enable that tells the register file which pointer to store.

The caller presents the mode, the pointer select and all candidate operands together with a request strobe. One clock later the block returns a registered result: the effective address, an I/O-space flag, the pointer write-back bundle and a flag for an illegal combination. The register file that assembles each pointer from its register pair lies outside the block, as do the memories and instruction decoding.

Top module: `data_addr_gen`

## Requirements
- R1: While reset is active, and on the first cycle after it, `outValid`, `wbEn`, `illegal` and `ioSpace` are 0, and `effAddr`, `wbData` and `wbSel` are 0.
- R2: A request sampled on a rising edge produces its result with `outValid`=1 after that same edge. A cycle with `reqValid`=0 drives `outValid`, `wbEn` and `illegal` to 0 and leaves `effAddr`, `ioSpace`, `wbData` and `wbSel` unchanged. Mode codes are 0 indirect, 1 pre-decrement, 2 post-increment, 3 displacement, 4 I/O direct and 5 data direct.
- R3: The pointer select codes are 0 for X (`ptrX`), 1 for Y (`ptrY`) and 2 for Z (`ptrZ`). In indirect mode the effective address is the selected pointer, with `wbEn`=0.
- R4: In pre-decrement mode the effective address is the selected pointer minus 1, modulo 2^16. `wbData` carries the same value, `wbEn`=1 and `wbSel` equals the pointer select.
- R5: In post-increment mode the effective address is the selected pointer unchanged. `wbData` is the pointer plus 1, modulo 2^16, `wbEn`=1 and `wbSel` equals the pointer select.
- R6: In displacement mode with Y or Z selected, the effective address is the pointer plus the zero-extended 6-bit `disp`, modulo 2^16, with `wbEn`=0.
- R7: Selecting X in displacement mode, or select code 3 in any of modes 0 to 3, sets `illegal`=1 with `wbEn`=0, `effAddr`=0 and `ioSpace`=0.
- R8: In I/O direct mode `effAddr` is the zero-extended 6-bit `ioField` (0x00 to 0x3F), `ioSpace`=1 and `wbEn`=0. `ioSpace` is 0 in every other mode.
- R9: In data direct mode `effAddr` is `{segExt, directWord}` with `wbEn`=0. In modes 0 to 4, bits 23:16 of `effAddr` are 0.
- R10: Mode codes 6 and 7 set `illegal`=1 with `wbEn`=0, `effAddr`=0 and `ioSpace`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| ptrSel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| ptrX | input | 16 | X pointer value |
| ptrY | input | 16 | Y pointer value |
| ptrZ | input | 16 | Z pointer value |
| disp | input | 6 | Unsigned displacement |
| ioField | input | 6 | Peripheral register number |
| directWord | input | 16 | Address word of a two-word instruction |
| segExt | input | 8 | Data-segment extension |
| outValid | output | 1 | Result valid |
| effAddr | output | 24 | Effective address |
| ioSpace | output | 1 | Address lies in the peripheral space |
| wbData | output | 16 | Updated pointer value, meaningful when wbEn=1 |
| wbEn | output | 1 | Pointer write-back enable |
| wbSel | output | 2 | Pointer to write back |
| illegal | output | 1 | Illegal mode or pointer combination |

## Verification
A stuck or mis-decoded strobe in the control shows at the ports in the cycle right after the request. It appears as a wrong address, an I/O flag raised in a memory mode, or a pointer write-back in a mode that must not update a pointer. Because every result register is reloaded on each request, a bad internal value is visible in the first result computed from it and cannot stay hidden until a later cycle. The sweep walks every mode and select code across pointer values at the wrap points 0x0000, 0xFFFF and 0x7FFF/0x8000. Each pointer receives a different value, so a swapped pointer mux or a carry lost at the 16-bit boundary changes the compared address.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [2:0] {
    MD_IND     = 3'd0,
    MD_PREDEC  = 3'd1,
    MD_POSTINC = 3'd2,
    MD_DISP    = 3'd3,
    MD_IO      = 3'd4,
    MD_DIRECT  = 3'd5,
    MD_RSV6    = 3'd6,
    MD_RSV7    = 3'd7
  } modeE;

  typedef enum logic [1:0] {
    OFF_ZERO   = 2'd0,
    OFF_PLUS1  = 2'd1,
    OFF_MINUS1 = 2'd2,
    OFF_DISP   = 2'd3
  } offE;

  typedef struct packed {
    logic load;        // capture a new result
    logic addrFromSum; // pointer-path address is the adder output
    offE  offSel;      // adder offset choice
    logic usePtr;      // address from pointer path
    logic useIo;       // address from I/O field
    logic useDirect;   // address from direct word + segment
    logic wbEn;        // pointer write-back
    logic illegal;     // illegal combination
  } strobesT;

endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] mode,
  input  logic [1:0] ptrSel,
  output strobesT    strb
);

  logic selOk;
  logic dispOk;

  assign selOk  = (ptrSel != 2'd3);
  assign dispOk = selOk && (ptrSel != 2'd0);

  always_comb begin
    strb = '0;
    strb.offSel = OFF_ZERO;
    strb.load = reqValid;
    if (reqValid) begin
      unique case (modeE'(mode))
        MD_IND: begin
          strb.usePtr  = selOk;
          strb.illegal = !selOk;
        end
        MD_PREDEC: begin
          strb.usePtr      = selOk;
          strb.offSel      = OFF_MINUS1;
          strb.addrFromSum = 1'b1;
          strb.wbEn        = selOk;
          strb.illegal     = !selOk;
        end
        MD_POSTINC: begin
          strb.usePtr  = selOk;
          strb.offSel  = OFF_PLUS1;
          strb.wbEn    = selOk;
          strb.illegal = !selOk;
        end
        MD_DISP: begin
          strb.usePtr      = dispOk;
          strb.offSel      = OFF_DISP;
          strb.addrFromSum = 1'b1;
          strb.illegal     = !dispOk;
        end
        MD_IO:     strb.useIo = 1'b1;
        MD_DIRECT: strb.useDirect = 1'b1;
        default:   strb.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DISP_W = 6,
  parameter int IO_W   = 6,
  parameter int SEG_W  = 8,
  parameter int NPTR   = 3,
  localparam int ADDR_W = SEG_W + PTR_W,
  localparam int SEL_W  = $clog2(NPTR + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobesT           strb,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic [PTR_W-1:0]  ptrIn [NPTR],
  input  logic [DISP_W-1:0] disp,
  input  logic [IO_W-1:0]   ioField,
  input  logic [PTR_W-1:0]  directWord,
  input  logic [SEG_W-1:0]  segExt,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              ioSpace,
  output logic [PTR_W-1:0]  wbData,
  output logic              wbEn,
  output logic [SEL_W-1:0]  wbSel,
  output logic              illegal
);

  logic [PTR_W-1:0]  ptrVal;
  logic [PTR_W-1:0]  offset;
  logic [PTR_W-1:0]  ptrSum;
  logic [PTR_W-1:0]  ptrAddr;
  logic [PTR_W-1:0]  dispExt;
  logic [ADDR_W-1:0] nextAddr;

  // Pointer select mux; out-of-range codes yield zero
  always_comb begin
    ptrVal = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (ptrSel == SEL_W'(i)) ptrVal = ptrIn[i];
    end
  end

  generate
    if (DISP_W >= PTR_W) begin : g_dispTrunc
      assign dispExt = disp[PTR_W-1:0];
    end else begin : g_dispZext
      assign dispExt = {{(PTR_W-DISP_W){1'b0}}, disp};
    end
  endgenerate

  always_comb begin
    unique case (strb.offSel)
      OFF_PLUS1:  offset = PTR_W'(1);
      OFF_MINUS1: offset = '1;
      OFF_DISP:   offset = dispExt;
      default:    offset = '0;
    endcase
  end

  assign ptrSum  = ptrVal + offset;
  assign ptrAddr = strb.addrFromSum ? ptrSum : ptrVal;

  always_comb begin
    nextAddr = '0;
    if (strb.usePtr)    nextAddr = {{SEG_W{1'b0}}, ptrAddr};
    if (strb.useIo)     nextAddr = ADDR_W'(ioField);
    if (strb.useDirect) nextAddr = {segExt, directWord};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      ioSpace  <= 1'b0;
      wbData   <= '0;
      wbEn     <= 1'b0;
      wbSel    <= '0;
      illegal  <= 1'b0;
    end else if (strb.load) begin
      outValid <= 1'b1;
      effAddr  <= nextAddr;
      ioSpace  <= strb.useIo;
      wbData   <= strb.wbEn ? ptrSum : '0;
      wbEn     <= strb.wbEn;
      wbSel    <= strb.wbEn ? ptrSel : '0;
      illegal  <= strb.illegal;
    end else begin
      outValid <= 1'b0;
      wbEn     <= 1'b0;
      illegal  <= 1'b0;
    end
  end

endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DISP_W = 6,
  parameter int IO_W   = 6,
  parameter int SEG_W  = 8,
  localparam int ADDR_W = SEG_W + PTR_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        mode,
  input  logic [1:0]        ptrSel,
  input  logic [PTR_W-1:0]  ptrX,
  input  logic [PTR_W-1:0]  ptrY,
  input  logic [PTR_W-1:0]  ptrZ,
  input  logic [DISP_W-1:0] disp,
  input  logic [IO_W-1:0]   ioField,
  input  logic [PTR_W-1:0]  directWord,
  input  logic [SEG_W-1:0]  segExt,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              ioSpace,
  output logic [PTR_W-1:0]  wbData,
  output logic              wbEn,
  output logic [1:0]        wbSel,
  output logic              illegal
);

  strobesT          strb;
  logic [PTR_W-1:0] ptrArr [3];

  assign ptrArr[0] = ptrX;
  assign ptrArr[1] = ptrY;
  assign ptrArr[2] = ptrZ;

  dag_ctrl u_ctrl (
    .reqValid (reqValid),
    .mode     (mode),
    .ptrSel   (ptrSel),
    .strb     (strb)
  );

  dag_datapath #(
    .PTR_W  (PTR_W),
    .DISP_W (DISP_W),
    .IO_W   (IO_W),
    .SEG_W  (SEG_W),
    .NPTR   (3)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ptrSel     (ptrSel),
    .ptrIn      (ptrArr),
    .disp       (disp),
    .ioField    (ioField),
    .directWord (directWord),
    .segExt     (segExt),
    .outValid   (outValid),
    .effAddr    (effAddr),
    .ioSpace    (ioSpace),
    .wbData     (wbData),
    .wbEn       (wbEn),
    .wbSel      (wbSel),
    .illegal    (illegal)
  );

endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk #(
  parameter int PTR_W  = 16,
  parameter int IO_W   = 6,
  parameter int SEG_W  = 8,
  localparam int ADDR_W = SEG_W + PTR_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        mode,
  input logic              outValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic              ioSpace,
  input logic [PTR_W-1:0]  wbData,
  input logic              wbEn,
  input logic              illegal
);

  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !wbEn && !illegal)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !reqValid) |=> $stable(effAddr)); // R2

  AST_PREDEC_WB: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd1) |=> (illegal || (wbEn && wbData == effAddr[PTR_W-1:0]))); // R4

  AST_POSTINC_WB: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd2) |=> (illegal || (wbEn && wbData == effAddr[PTR_W-1:0] + PTR_W'(1)))); // R5

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!wbEn && !ioSpace && effAddr == '0)); // R7

  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ioSpace |-> (effAddr >> IO_W) == '0); // R8

  AST_RSV_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode[2:1] == 2'b11) |=> (illegal && !wbEn)); // R10

  AST_NO_WB_STATIC: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (mode == 3'd0 || mode == 3'd3 || mode == 3'd4 || mode == 3'd5)) |=> !wbEn); // R6

endmodule

bind data_addr_gen data_addr_gen_chk #(
  .PTR_W (PTR_W),
  .IO_W  (IO_W),
  .SEG_W (SEG_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .mode     (mode),
  .outValid (outValid),
  .effAddr  (effAddr),
  .ioSpace  (ioSpace),
  .wbData   (wbData),
  .wbEn     (wbEn),
  .illegal  (illegal)
);

// File: tb/data_addr_gen_bench.sv
`timescale 1ns/1ps
module data_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptrSel = '0;
  logic [15:0] ptrX = '0, ptrY = '0, ptrZ = '0;
  logic [5:0]  disp = '0, ioField = '0;
  logic [15:0] directWord = '0;
  logic [7:0]  segExt = '0;
  logic        outValid, ioSpace, wbEn, illegal;
  logic [23:0] effAddr;
  logic [15:0] wbData;
  logic [1:0]  wbSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  data_addr_gen u_data_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .ptrSel(ptrSel),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ), .disp(disp), .ioField(ioField),
    .directWord(directWord), .segExt(segExt), .outValid(outValid),
    .effAddr(effAddr), .ioSpace(ioSpace), .wbData(wbData), .wbEn(wbEn),
    .wbSel(wbSel), .illegal(illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R8";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  logic [15:0] pat [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234};
  logic [5:0]  dpat [4] = '{6'h00, 6'h01, 6'h3F, 6'h2A};
  logic [7:0]  spat [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {outValid, wbEn, illegal, ioSpace, effAddr, wbData, wbSel},
          64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", {outValid, wbEn, illegal, ioSpace, effAddr, wbData, wbSel}, 64'd0);

    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 6; i++) begin
          for (int j = 0; j < 4; j++) begin
            logic [15:0] pv, eWb;
            logic [23:0] eAddr;
            logic        eIll, eWe, eIo;
            @(negedge clk);
            reqValid = 1'b1;
            mode = 3'(m); ptrSel = 2'(s);
            ptrX = pat[i]; ptrY = pat[(i+2)%6]; ptrZ = pat[(i+4)%6];
            disp = dpat[j]; ioField = dpat[(j+1)%4];
            directWord = pat[(i+3)%6]; segExt = spat[j];
            pv = (s == 0) ? ptrX : (s == 1) ? ptrY : ptrZ;
            eIll = (m > 5) || (m < 4 && s == 3) || (m == 3 && s == 0);
            eWe = !eIll && (m == 1 || m == 2);
            eIo = (m == 4);
            eWb = 16'h0;
            eAddr = 24'h0;
            if (!eIll) begin
              case (m)
                0: eAddr = {8'h0, pv};
                1: begin eAddr = {8'h0, 16'(pv - 16'd1)}; eWb = pv - 16'd1; end
                2: begin eAddr = {8'h0, pv}; eWb = pv + 16'd1; end
                3: eAddr = {8'h0, 16'(pv + {10'h0, disp})};
                4: eAddr = {18'h0, ioField};
                default: eAddr = {segExt, directWord};
              endcase
            end
            @(posedge clk); #1;
            check(eIll ? "R7" : tagOf(m), {outValid, illegal, wbEn, ioSpace, effAddr},
                  {1'b1, eIll, eWe, eIo, eAddr});
            if (eWe)
              check(tagOf(m), {wbData, wbSel}, {eWb, 2'(s)});
          end
        end
      end
      // R2: idle cycle holds address, drops strobes
      begin
        logic [23:0] lastAddr;
        logic        lastIo;
        lastAddr = effAddr; lastIo = ioSpace;
        @(negedge clk);
        reqValid = 1'b0;
        mode = 3'd1; ptrX = 16'hABCD; ptrY = 16'hABCD; ptrZ = 16'hABCD;
        @(posedge clk); #1;
        check("R2", {outValid, wbEn, illegal, ioSpace, effAddr},
              {3'b000, lastIo, lastAddr});
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule